// File: doc/BRIEF.md
# I2C Target Register Bank

This block is an I2C target that gives a bus host read and write access to a bank of 8-bit registers. The current value of every register is also driven out on one wide parallel port, so user logic can take control values from it. SCL and SDA are sampled with the system clock, and SDA is driven only through an open-drain pull-down enable.

A transaction opens with START and a 7-bit device address. The address is fixed by a parameter. In a write, the first byte that follows the address sets the register pointer. Every byte after that is stored at the pointer, and the pointer then advances. In a read, each byte is taken from the pointer, and the pointer advances after it. There is only one pointer, and it serves both directions. Bursts can be any length and wrap at the top of the bank. STOP does not clear the pointer, and reset does not either, so a host sets it before its first read. To read from a chosen register, the host writes the pointer byte and then issues a repeated START with the read address.

Top module: `i2c_regfile_target`

## Requirements
- R1: While reset is asserted and right after it, sda_oe is 0 and every register reads 0 on regs_o.
- R2: In the ninth clock, the target pulls SDA low to acknowledge the address byte {DEV_ADDR, rw}, where rw=1 means read. Any other address gets no acknowledge, and the bytes that follow are neither acknowledged nor stored until the next START.
- R3: The first byte of a write transaction loads the pointer. Every later byte is acknowledged, stored in register [pointer], and then the pointer advances by one. Register i appears on regs_o[8*i+7 : 8*i].
- R4: Read data leaves MSB first and comes from register [pointer]. The pointer then advances by one, so a burst returns consecutive registers.
- R5: The pointer wraps from 255 to 0 in both write and read bursts.
- R6: A repeated START after the pointer byte begins a read at that pointer value.
- R7: After the host answers a read byte with NACK (SDA high in the ninth clock), the target keeps SDA released.
- R8: sda_oe changes only while SCL is low.
- R9: The pointer keeps its value across STOP and a new START. A read that does not set the pointer again carries on where the last access ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low |
| regs_o | output | NREG*8 | All registers, register i on bits 8*i+7 down to 8*i |

## Verification
Each bus line passes through two sync stages and one edge register. The FSM acts on the detected SCL edge, and its outputs are registered. So sda_oe settles about four system clocks after a SCL fall, and regs_o updates one clock after the FSM's write strobe. The bench holds each SCL phase for 20 system clocks. It reads the acknowledge bit and read data in the middle of SCL high, and it checks regs_o and the released SDA only after the next full phase has elapsed. None of these samples falls inside the few cycles where the synchronised result is still moving. A monitor checks every cycle that sda_oe never moves while SCL is high.

// File: rtl/i2c_rf_pkg.sv
package i2c_rf_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,   // not addressed
    ST_ADDR,   // shifting in address byte
    ST_AACK,   // acknowledging own address
    ST_RX,     // shifting in write byte
    ST_RACK,   // acknowledging write byte
    ST_TX,     // shifting out read byte
    ST_TACK    // sampling host ACK/NACK
  } tgt_state_e;
endpackage

// File: rtl/i2c_rf_sync.sv
module i2c_rf_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic start_o,
  output logic stop_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] scl_pipe_q, sda_pipe_q;
  logic              scl_d_q, sda_d_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe_q <= '1;
      sda_pipe_q <= '1;
      scl_d_q    <= 1'b1;
      sda_d_q    <= 1'b1;
    end else begin
      scl_pipe_q <= {scl_pipe_q[STAGES-2:0], scl_i};
      sda_pipe_q <= {sda_pipe_q[STAGES-2:0], sda_i};
      scl_d_q    <= scl_pipe_q[STAGES-1];
      sda_d_q    <= sda_pipe_q[STAGES-1];
    end
  end

  assign scl_o   = scl_pipe_q[STAGES-1];
  assign sda_o   = sda_pipe_q[STAGES-1];
  // SDA edges while SCL stays high mark bus conditions
  assign start_o = scl_o & scl_d_q & sda_d_q & ~sda_o;
  assign stop_o  = scl_o & scl_d_q & ~sda_d_q & sda_o;
  assign rise_o  = scl_o & ~scl_d_q;
  assign fall_o  = ~scl_o & scl_d_q;
endmodule

// File: rtl/i2c_rf_bank.sv
module i2c_rf_bank #(
  parameter int NREG = 256,
  localparam int PW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [7:0]      wr_data,
  input  logic            ptr_ld,
  input  logic [7:0]      ptr_val,
  input  logic            ptr_inc,
  output logic [7:0]      rdata,
  output logic [PW-1:0]   ptr_o,
  output logic [NREG*8-1:0] regs_o
);
  logic [PW-1:0] ptr_q, ptr_d;
  logic [7:0]    mem_q [NREG];

  // pointer: deliberately left without reset
  always_comb begin
    ptr_d = ptr_q;
    if (ptr_ld)       ptr_d = ptr_val[PW-1:0];
    else if (ptr_inc) ptr_d = ptr_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    ptr_q <= ptr_d;
  end

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             mem_q[g] <= 8'h00;
      else if (wr_en && ptr_q == PW'(g))      mem_q[g] <= wr_data;
    end
    assign regs_o[g*8 +: 8] = mem_q[g];
  end

  assign rdata = mem_q[ptr_q];
  assign ptr_o = ptr_q;
endmodule

// File: rtl/i2c_rf_fsm.sv
module i2c_rf_fsm
  import i2c_rf_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h2A
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sda,
  input  logic       start,
  input  logic       stop,
  input  logic       rise,
  input  logic       fall,
  input  logic [7:0] rdata,
  output logic       sda_oe,
  output logic       wr_en,
  output logic [7:0] wr_data,
  output logic       ptr_ld,
  output logic       ptr_inc,
  output tgt_state_e state
);
  tgt_state_e state_q, state_d;
  logic [3:0] cnt_q, cnt_d;
  logic [7:0] sh_q, sh_d;
  logic       rw_q, rw_d, first_q, first_d, nack_q, nack_d, oe_q, oe_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    rw_d    = rw_q;
    first_d = first_q;
    nack_d  = nack_q;
    oe_d    = oe_q;
    wr_en   = 1'b0;
    ptr_ld  = 1'b0;
    ptr_inc = 1'b0;
    if (start) begin
      state_d = ST_ADDR;
      cnt_d   = '0;
      oe_d    = 1'b0;
    end else if (stop) begin
      state_d = ST_IDLE;
      oe_d    = 1'b0;
    end else begin
      case (state_q)
        ST_ADDR, ST_RX: begin
          if (rise && cnt_q != 4'd8) begin
            sh_d  = {sh_q[6:0], sda};
            cnt_d = cnt_q + 4'd1;
          end else if (fall && cnt_q == 4'd8) begin
            if (state_q == ST_ADDR) begin
              if (sh_q[7:1] == DEV_ADDR) begin
                rw_d    = sh_q[0];
                oe_d    = 1'b1;
                state_d = ST_AACK;
              end else begin
                state_d = ST_IDLE;
              end
            end else begin
              oe_d    = 1'b1;
              state_d = ST_RACK;
              if (first_q) begin
                ptr_ld  = 1'b1;
                first_d = 1'b0;
              end else begin
                wr_en   = 1'b1;
                ptr_inc = 1'b1;
              end
            end
          end
        end
        ST_AACK: if (fall) begin
          cnt_d = '0;
          if (rw_q) begin
            sh_d    = rdata;
            oe_d    = ~rdata[7];
            state_d = ST_TX;
          end else begin
            oe_d    = 1'b0;
            first_d = 1'b1;
            state_d = ST_RX;
          end
        end
        ST_RACK: if (fall) begin
          oe_d    = 1'b0;
          cnt_d   = '0;
          state_d = ST_RX;
        end
        ST_TX: if (fall) begin
          if (cnt_q == 4'd7) begin
            oe_d    = 1'b0;
            ptr_inc = 1'b1;
            state_d = ST_TACK;
          end else begin
            sh_d  = {sh_q[6:0], 1'b0};
            oe_d  = ~sh_q[6];
            cnt_d = cnt_q + 4'd1;
          end
        end
        ST_TACK: begin
          if (rise) nack_d = sda;
          if (fall) begin
            if (!nack_q) begin
              sh_d    = rdata;
              oe_d    = ~rdata[7];
              cnt_d   = '0;
              state_d = ST_TX;
            end else begin
              state_d = ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      rw_q    <= 1'b0;
      first_q <= 1'b0;
      nack_q  <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      rw_q    <= rw_d;
      first_q <= first_d;
      nack_q  <= nack_d;
      oe_q    <= oe_d;
    end
  end

  assign sda_oe  = oe_q;
  assign wr_data = sh_q;
  assign state   = state_q;
endmodule

// File: rtl/i2c_regfile_target.sv
module i2c_regfile_target
  import i2c_rf_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h2A,
  parameter int         NREG     = 256,
  localparam int        PW       = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe,
  output logic [NREG*8-1:0] regs_o
);
  logic          scl_s, sda_s, start_det, stop_det, scl_rise, scl_fall;
  logic [7:0]    rdata, wr_data;
  logic          wr_en, ptr_ld, ptr_inc;
  logic [PW-1:0] ptr;
  tgt_state_e    state;

  i2c_rf_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_o(scl_s), .sda_o(sda_s), .start_o(start_det), .stop_o(stop_det),
    .rise_o(scl_rise), .fall_o(scl_fall)
  );

  i2c_rf_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
    .clk(clk), .rst_n(rst_n), .sda(sda_s), .start(start_det), .stop(stop_det),
    .rise(scl_rise), .fall(scl_fall), .rdata(rdata), .sda_oe(sda_oe),
    .wr_en(wr_en), .wr_data(wr_data), .ptr_ld(ptr_ld), .ptr_inc(ptr_inc),
    .state(state)
  );

  i2c_rf_bank #(.NREG(NREG)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .ptr_ld(ptr_ld), .ptr_val(wr_data), .ptr_inc(ptr_inc), .rdata(rdata),
    .ptr_o(ptr), .regs_o(regs_o)
  );
endmodule

// File: rtl/i2c_rf_checker.sv
module i2c_rf_checker
  import i2c_rf_pkg::*;
#(
  parameter int NREG = 256,
  localparam int PW = $clog2(NREG)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_s,
  input logic          sda_oe,
  input logic          start_det,
  input logic          wr_en,
  input logic          ptr_ld,
  input logic          ptr_inc,
  input logic [PW-1:0] ptr,
  input tgt_state_e    state
);
  a_r8_oe_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(sda_oe) |-> !scl_s);

  a_r3_store_then_ack: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> sda_oe);

  a_r5_ptr_step_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_inc && !ptr_ld) |=> (ptr == $past(ptr) + PW'(1)));

  a_r2_drive_only_when_owed: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> (state == ST_AACK || state == ST_RACK || state == ST_TX));

  a_r6_start_restarts_addr: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (state == ST_ADDR && !sda_oe));
endmodule

bind i2c_regfile_target i2c_rf_checker #(.NREG(NREG)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_oe(sda_oe),
  .start_det(start_det), .wr_en(wr_en), .ptr_ld(ptr_ld), .ptr_inc(ptr_inc),
  .ptr(ptr), .state(state)
);

// File: tb/test_i2c_regfile_target.sv
module test_i2c_regfile_target;
  localparam logic [6:0] DEV = 7'h2A;
  localparam int NREG = 256;
  localparam int Q = 20;
  localparam logic [15:0] VEC [8] = '{
    {8'h00, 8'h5A}, {8'h01, 8'hA5}, {8'h10, 8'h3C}, {8'h7F, 8'hFF},
    {8'h80, 8'h01}, {8'hC3, 8'h80}, {8'hFE, 8'h69}, {8'hFF, 8'h96}
  };

  logic clk, rst_n, scl, sda_m, sda_oe, sda_bus;
  logic [NREG*8-1:0] regs;
  int n_chk = 0, n_err = 0, r8_viol = 0;
  logic prev_oe;

  assign sda_bus = sda_m & ~sda_oe;

  i2c_regfile_target #(.DEV_ADDR(DEV), .NREG(NREG)) i_i2c_regfile_target (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
    .sda_oe(sda_oe), .regs_o(regs)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // R8 monitor: SDA enable must never move with SCL high
  always @(negedge clk) begin
    if (rst_n && scl && sda_oe !== prev_oe) r8_viol++;
    prev_oe <= sda_oe;
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(); scl = 1'b1; wq(); sda_m = 1'b0; wq(); scl = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(); scl = 1'b1; wq(); sda_m = 1'b1; wq();
  endtask

  task automatic wr_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq();
    end
    sda_m = 1'b1; wq(); scl = 1'b1; wq(); ack = ~sda_bus; wq(); scl = 1'b0; wq();
  endtask

  task automatic rd_byte(output logic [7:0] d, input logic give_ack);
    for (int i = 0; i < 8; i++) begin
      sda_m = 1'b1; wq(); scl = 1'b1; wq(); d = {d[6:0], sda_bus}; wq(); scl = 1'b0; wq();
    end
    sda_m = ~give_ack; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq();
    sda_m = 1'b1;
  endtask

  logic ack;
  logic [7:0] d;

  initial begin
    rst_n = 1'b0; scl = 1'b1; sda_m = 1'b1;
    repeat (10) @(negedge clk);
    chk("R1 oe in reset", {7'd0, sda_oe}, 8'h00);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 oe after reset", {7'd0, sda_oe}, 8'h00);
    chk("R1 regs zero", {7'd0, |regs}, 8'h00);

    // table walk: single write, then pointer write + repeated START read
    for (int k = 0; k < 8; k++) begin
      bus_start();
      wr_byte({DEV, 1'b0}, ack); chk("R2 address ack", {7'd0, ack}, 8'h01);
      wr_byte(VEC[k][15:8], ack); chk("R3 pointer ack", {7'd0, ack}, 8'h01);
      wr_byte(VEC[k][7:0], ack);  chk("R3 data ack", {7'd0, ack}, 8'h01);
      bus_stop();
      chk("R3 regs_o", regs[VEC[k][15:8]*8 +: 8], VEC[k][7:0]);
      bus_start();
      wr_byte({DEV, 1'b0}, ack);
      wr_byte(VEC[k][15:8], ack);
      bus_start();
      wr_byte({DEV, 1'b1}, ack); chk("R6 read address ack", {7'd0, ack}, 8'h01);
      rd_byte(d, 1'b0);
      chk("R4 R6 readback", d, VEC[k][7:0]);
      bus_stop();
    end

    // R5 write burst across the top: FD,FE,FF,00
    bus_start();
    wr_byte({DEV, 1'b0}, ack);
    wr_byte(8'hFD, ack);
    wr_byte(8'h11, ack); wr_byte(8'h22, ack); wr_byte(8'h33, ack); wr_byte(8'h44, ack);
    chk("R3 burst byte ack", {7'd0, ack}, 8'h01);
    bus_stop();
    chk("R5 wr FD", regs[8'hFD*8 +: 8], 8'h11);
    chk("R5 wr FF", regs[8'hFF*8 +: 8], 8'h33);
    chk("R5 wr wrap 00", regs[0 +: 8], 8'h44);

    // R9 pointer now 01; read without setting it
    bus_start();
    wr_byte({DEV, 1'b1}, ack);
    rd_byte(d, 1'b0);
    chk("R9 pointer kept", d, 8'hA5);
    bus_stop();

    // R5 read burst across the top from FE
    bus_start();
    wr_byte({DEV, 1'b0}, ack);
    wr_byte(8'hFE, ack);
    bus_start();
    wr_byte({DEV, 1'b1}, ack);
    rd_byte(d, 1'b1); chk("R4 burst FE", d, 8'h22);
    rd_byte(d, 1'b1); chk("R4 burst FF", d, 8'h33);
    rd_byte(d, 1'b1); chk("R5 rd wrap 00", d, 8'h44);
    rd_byte(d, 1'b0); chk("R5 rd 01", d, 8'hA5);
    // R7 after NACK the line stays released for a further byte of clocks
    for (int i = 0; i < 9; i++) begin
      wq(); scl = 1'b1; wq();
      chk("R7 released after NACK", {7'd0, sda_bus}, 8'h01);
      wq(); scl = 1'b0; wq();
    end
    bus_stop();

    // R2 foreign address: no ack, bytes ignored
    bus_start();
    wr_byte({7'h2B, 1'b0}, ack); chk("R2 foreign no ack", {7'd0, ack}, 8'h00);
    wr_byte(8'h10, ack); chk("R2 ignored byte no ack", {7'd0, ack}, 8'h00);
    wr_byte(8'hEE, ack);
    bus_stop();
    chk("R2 register untouched", regs[8'h10*8 +: 8], 8'h3C);

    chk("R8 oe moved with SCL high", r8_viol[7:0], 8'h00);

    // R1 reset clears bank
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 regs cleared by reset", {7'd0, |regs}, 8'h00);
    chk("R1 oe cleared by reset", {7'd0, sda_oe}, 8'h00);
    rst_n = 1'b1;

    $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule